// File: doc/BRIEF.md
# Dual-Slot Conditional-Access Card Bus Controller

This block sits between a host register port and two common-interface card slots. The host loads a 14-bit card address across two byte registers. It picks the slot and the address space (attribute memory or control registers) in a bus-control byte, then reads or writes a data register. Each data-register access runs exactly one strobed cycle on the chosen slot's card-side pins. The cycle stretches while that card holds its wait line. A read returns the card's byte.

The same bus-control byte has three more jobs. It starts a per-slot card reset that clears itself, so the host polls it until the reset is done. It enables transport-stream routing through each slot. It reports whether a card sits in each slot. A second control byte drives two transport-stream output enables and two active-low tuner resets. An interrupt flag records any change of card presence while interrupts are enabled.

Top module: `cam_slot_ctrl`

## Requirements
- R1: Address low register (offset 2) stores card address bits 6..0 in its bits 7..1 and reads bit 0 as 0. Address high register (offset 3) stores bits 13..7 in its bits 6..0 and reads bit 7 as 0. `card_addr` presents the 14-bit address and holds steady throughout a card cycle.
- R2: Bus-control register (offset 5) bit 7 selects the slot (0 or 1) and bit 6 selects the space (1 = control, 0 = attribute). During a card cycle only the selected slot's `card_ce_n` bit is low, and `card_space` equals bit 6.
- R3: A host read of the data register (offset 4) performs exactly one card cycle with `card_oe_n` strobed. It returns on `host_rdata` the `card_rdata` byte present at the end of the strobe, with `host_ack` high.
- R4: A host write of the data register performs exactly one card cycle with `card_we_n` strobed, and `card_wdata` carries the written byte.
- R5: In a card cycle, chip enable goes low one cycle before the strobe. The strobe stays low for STB_CYC cycles, or longer while the selected slot's `card_wait_n` is low. Read and write strobes are never low together.
- R6: Writing 1 to bus-control bit 5 (slot 0) or bit 4 (slot 1) drives that slot's `card_rst` high for exactly RST_CYC cycles. The bit then reads 1 for SETTLE_CYC further cycles before it clears itself. Writing 0 to a running reset bit has no effect.
- R7: Bus-control bit 3 drives `ts_route[0]` and bit 2 drives `ts_route[1]`.
- R8: Bus-control bit 1 reads the synchronised `card_cd_n[0]` and bit 0 reads `card_cd_n[1]`, so each reads 0 when a card is present. Host writes to these bits are ignored.
- R9: Control-2 register (offset 1) bit 4 drives `ts_out_en[0]` and bit 5 drives `ts_out_en[1]`. Bit 3 drives `tuner_rst_n[0]` and bit 2 drives `tuner_rst_n[1]`. It reads back bits 5..2.
- R10: Interrupt register (offset 0) bit 0 enables interrupts. While enabled, a change of either synchronised card-detect input sets the pending flag (read at bit 1), and `irq_n` goes low. A read of this register clears the flag. A change while disabled sets nothing.
- R11: After reset, `host_ack`, `card_rst`, `ts_route` and `ts_out_en` are 0. `irq_n`, `card_ce_n`, `card_oe_n`, `card_we_n` and `tuner_rst_n` are all 1. Control-2 reads 0x0C, and the address and interrupt registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle host access request, taken when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, valid with host_ack |
| host_ack | output | 1 | Access complete pulse |
| irq_n | output | 1 | Active-low interrupt |
| card_addr | output | 14 | Card address |
| card_wdata | output | 8 | Card write byte |
| card_rdata | input | 8 | Card read byte |
| card_space | output | 1 | 1 = control space, 0 = attribute memory |
| card_ce_n | output | 2 | Per-slot active-low card enable |
| card_oe_n | output | 1 | Active-low read strobe |
| card_we_n | output | 1 | Active-low write strobe |
| card_wait_n | input | 2 | Per-slot active-low wait |
| card_cd_n | input | 2 | Per-slot active-low card detect |
| card_rst | output | 2 | Per-slot card reset, active high |
| ts_route | output | 2 | Per-slot stream routing enable |
| ts_out_en | output | 2 | Stream output enables |
| tuner_rst_n | output | 2 | Active-low tuner resets |

## Verification
The assertions assume that the host issues a new request only after the previous `host_ack`. They also assume that card detect and wait change only between clock edges. The bench's driver task blocks until each acknowledge, and it moves the card-side inputs on the falling edge. The bench holds the wait line of a slot low for a known number of falling edges after the strobe starts, so the stretched strobe length is known in advance. Before each reset-bit or interrupt check, the bench also lets card-detect changes settle through the two-stage synchroniser.

// File: rtl/cam_slot_ctrl.sv
module cam_slot_ctrl #(
  parameter int RST_CYC    = 16,
  parameter int SETTLE_CYC = 8,
  parameter int STB_CYC    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [3:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_ack,
  output logic        irq_n,
  output logic [13:0] card_addr,
  output logic [7:0]  card_wdata,
  input  logic [7:0]  card_rdata,
  output logic        card_space,
  output logic [1:0]  card_ce_n,
  output logic        card_oe_n,
  output logic        card_we_n,
  input  logic [1:0]  card_wait_n,
  input  logic [1:0]  card_cd_n,
  output logic [1:0]  card_rst,
  output logic [1:0]  ts_route,
  output logic [1:0]  ts_out_en,
  output logic [1:0]  tuner_rst_n
);
  localparam int RMAX = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int RCW  = $clog2(RMAX + 1);
  localparam int SCW  = $clog2(STB_CYC + 1);
  localparam logic [3:0] A_INT = 4'd0, A_CTL2 = 4'd1, A_ADLO = 4'd2,
                         A_ADHI = 4'd3, A_DATA = 4'd4, A_BUS = 4'd5;

  typedef enum logic [1:0] {AC_IDLE, AC_SETUP, AC_STROBE} acc_t;

  acc_t            ac_st;
  logic [SCW-1:0]  ac_cnt;
  logic            ac_we;
  logic            slot_q, space_q;
  logic [1:0]      route_q;
  logic [7:0]      ctl2_q;
  logic [13:0]     addr_q;
  logic            int_en, int_pend;
  logic [1:0]      cd_meta, cd_sync, cd_last;
  logic [7:0]      rdata_q, wdata_q, rd_mux;
  logic            ack_q;
  logic            rs_busy [2];
  logic            rs_hold [2];

  wire take    = host_req && ac_st == AC_IDLE;
  wire plain   = take && host_addr != A_DATA;
  wire bus_wr  = plain && host_we && host_addr == A_BUS;
  wire int_rd  = plain && !host_we && host_addr == A_INT;
  wire cd_chg  = |(cd_sync ^ cd_last);
  wire wait_ok = card_wait_n[slot_q];
  wire [7:0] bus_view = {slot_q, space_q, rs_busy[0], rs_busy[1],
                         route_q[0], route_q[1], cd_sync[0], cd_sync[1]};

  always_comb begin
    case (host_addr)
      A_INT:   rd_mux = {6'd0, int_pend, int_en};
      A_CTL2:  rd_mux = ctl2_q;
      A_ADLO:  rd_mux = {addr_q[6:0], 1'b0};
      A_ADHI:  rd_mux = {1'b0, addr_q[13:7]};
      A_BUS:   rd_mux = bus_view;
      default: rd_mux = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_st <= AC_IDLE; ac_cnt <= '0; ac_we <= 1'b0;
      slot_q <= 1'b0; space_q <= 1'b0; route_q <= 2'b00;
      ctl2_q <= 8'h0C; addr_q <= '0;
      int_en <= 1'b0; int_pend <= 1'b0;
      cd_meta <= 2'b11; cd_sync <= 2'b11; cd_last <= 2'b11;
      rdata_q <= 8'd0; wdata_q <= 8'd0; ack_q <= 1'b0;
    end else begin
      ack_q   <= 1'b0;
      cd_meta <= card_cd_n;
      cd_sync <= cd_meta;
      cd_last <= cd_sync;
      int_pend <= (int_en && cd_chg) || (int_pend && !int_rd);
      if (take && host_addr == A_DATA) begin
        ac_st <= AC_SETUP;
        ac_we <= host_we;
        if (host_we) wdata_q <= host_wdata;
      end else if (plain) begin
        ack_q <= 1'b1;
        if (!host_we) rdata_q <= rd_mux;
        else begin
          case (host_addr)
            A_INT:  int_en <= host_wdata[0];
            A_CTL2: ctl2_q <= host_wdata & 8'h3C;
            A_ADLO: addr_q[6:0] <= host_wdata[7:1];
            A_ADHI: addr_q[13:7] <= host_wdata[6:0];
            A_BUS: begin
              slot_q  <= host_wdata[7];
              space_q <= host_wdata[6];
              route_q <= {host_wdata[2], host_wdata[3]};
            end
            default: ;
          endcase
        end
      end
      case (ac_st)
        AC_SETUP: begin
          ac_st  <= AC_STROBE;
          ac_cnt <= '0;
        end
        AC_STROBE: begin
          if (ac_cnt == SCW'(STB_CYC - 1)) begin
            if (wait_ok) begin
              ac_st <= AC_IDLE;
              ack_q <= 1'b1;
              if (!ac_we) rdata_q <= card_rdata;
            end
          end else begin
            ac_cnt <= ac_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic [1:0]     ph;
    logic [RCW-1:0] cnt;
    wire start = bus_wr && host_wdata[5-g] && !rs_busy[g];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ph  <= 2'd0;
        cnt <= '0;
      end else if (start) begin
        ph  <= 2'd1;
        cnt <= '0;
      end else if (ph == 2'd1) begin
        if (cnt == RCW'(RST_CYC - 1)) begin
          ph  <= 2'd2;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
      end else if (ph == 2'd2) begin
        if (cnt == RCW'(SETTLE_CYC - 1)) ph <= 2'd0;
        else cnt <= cnt + 1'b1;
      end
    end
    assign rs_busy[g] = ph != 2'd0;
    assign rs_hold[g] = ph == 2'd1;
  end

  assign host_rdata   = rdata_q;
  assign host_ack     = ack_q;
  assign irq_n        = ~int_pend;
  assign card_addr    = addr_q;
  assign card_wdata   = wdata_q;
  assign card_space   = space_q;
  assign card_ce_n[0] = !(ac_st != AC_IDLE && !slot_q);
  assign card_ce_n[1] = !(ac_st != AC_IDLE && slot_q);
  assign card_oe_n    = !(ac_st == AC_STROBE && !ac_we);
  assign card_we_n    = !(ac_st == AC_STROBE && ac_we);
  assign card_rst     = {rs_hold[1], rs_hold[0]};
  assign ts_route     = route_q;
  assign ts_out_en    = ctl2_q[5:4];
  assign tuner_rst_n  = {ctl2_q[2], ctl2_q[3]};
endmodule

module cam_slot_ctrl_chk #(
  parameter int RST_CYC = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [13:0] card_addr,
  input logic        card_space,
  input logic [1:0]  card_ce_n,
  input logic        card_oe_n,
  input logic        card_we_n,
  input logic [1:0]  card_wait_n,
  input logic [1:0]  card_rst
);
  int hold0, hold1;
  wire slot_on   = card_ce_n != 2'b11;
  wire strb      = !card_oe_n || !card_we_n;
  wire wait_sel  = (!card_ce_n[0] && !card_wait_n[0]) || (!card_ce_n[1] && !card_wait_n[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold0 <= 0;
      hold1 <= 0;
    end else begin
      hold0 <= card_rst[0] ? hold0 + 1 : 0;
      hold1 <= card_rst[1] ? hold1 + 1 : 0;
    end
  end

  AST_ONE_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~card_ce_n)); // R2
  AST_STROBE_IN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) strb |-> slot_on); // R5
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(!card_oe_n && !card_we_n)); // R5
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n) (strb && wait_sel) |=> strb); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (slot_on && $past(slot_on)) |-> ($stable(card_addr) && $stable(card_space))); // R1
  AST_RST0_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(card_rst[0]) |-> hold0 == RST_CYC); // R6
  AST_RST1_LENGTH: assert property (@(posedge clk) disable iff (!rst_n) $fell(card_rst[1]) |-> hold1 == RST_CYC); // R6
endmodule

bind cam_slot_ctrl cam_slot_ctrl_chk #(.RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .card_addr(card_addr), .card_space(card_space),
  .card_ce_n(card_ce_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
  .card_wait_n(card_wait_n), .card_rst(card_rst)
);

// File: tb/sim_cam_slot_ctrl.sv
`timescale 1ns/1ps
module sim_cam_slot_ctrl;
  localparam int RST_CYC = 16, SETTLE_CYC = 8, STB_CYC = 3;
  localparam logic [3:0] A_INT = 4'd0, A_CTL2 = 4'd1, A_ADLO = 4'd2,
                         A_ADHI = 4'd3, A_DATA = 4'd4, A_BUS = 4'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [3:0] host_addr = 4'd0;
  logic [7:0] host_wdata = 8'd0, host_rdata, card_wdata, card_rdata;
  logic host_ack, irq_n, card_space, card_oe_n, card_we_n;
  logic [13:0] card_addr;
  logic [1:0] card_ce_n, card_rst, ts_route, ts_out_en, tuner_rst_n;
  logic [1:0] card_wait_n = 2'b11, card_cd_n = 2'b10;

  always #4 clk = ~clk;

  function automatic logic [7:0] card_byte(logic slot, logic sp, logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ (slot ? 8'h5A : 8'h00) ^ (sp ? 8'h81 : 8'h00);
  endfunction
  assign card_rdata = card_byte(!card_ce_n[1], card_space, card_addr);

  cam_slot_ctrl #(.RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .STB_CYC(STB_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ack(host_ack), .irq_n(irq_n), .card_addr(card_addr),
    .card_wdata(card_wdata), .card_rdata(card_rdata), .card_space(card_space),
    .card_ce_n(card_ce_n), .card_oe_n(card_oe_n), .card_we_n(card_we_n),
    .card_wait_n(card_wait_n), .card_cd_n(card_cd_n), .card_rst(card_rst),
    .ts_route(ts_route), .ts_out_en(ts_out_en), .tuner_rst_n(tuner_rst_n));

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  typedef struct { logic [7:0] ex; logic [7:0] mk; string tag; } item_t;
  item_t sb_q[$];
  logic [7:0] last_rd;

  always @(negedge clk) begin : monitor
    item_t it;
    if (rst_n && host_ack) begin
      if (sb_q.size() == 0) chk(1'b0, "scoreboard unexpected ack", 1, 0);
      else begin
        it = sb_q.pop_front();
        if (it.mk != 8'd0)
          chk(((host_rdata ^ it.ex) & it.mk) == 8'd0, it.tag,
              int'(host_rdata & it.mk), int'(it.ex & it.mk));
      end
    end
  end

  int strb_run = 0, last_len = 0, acc_cnt = 0, rh0 = 0, rh1 = 0;
  logic [1:0] ce_prev = 2'b11, seen_ce;
  logic [13:0] seen_addr;
  logic seen_space, seen_rd, seen_wr;
  logic [7:0] seen_wd;
  always @(negedge clk) begin
    if (!card_oe_n || !card_we_n) begin
      strb_run++;
      seen_addr = card_addr; seen_space = card_space; seen_ce = card_ce_n;
      seen_rd = !card_oe_n; seen_wr = !card_we_n;
      if (!card_we_n) seen_wd = card_wdata;
    end else if (strb_run != 0) begin
      last_len = strb_run;
      strb_run = 0;
    end
    if (card_ce_n != 2'b11 && ce_prev == 2'b11) acc_cnt++;
    ce_prev = card_ce_n;
    if (card_rst[0]) rh0++;
    if (card_rst[1]) rh1++;
  end

  task automatic acc(bit we, logic [3:0] a, logic [7:0] wd, logic [7:0] ex, logic [7:0] mk, string tag);
    sb_q.push_back('{ex, mk, tag});
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_ack) @(negedge clk);
    last_rd = host_rdata;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    acc(1'b1, a, d, 8'd0, 8'd0, "");
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [13:0] ea;
    int n0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state at the ports
    chk(host_ack == 1'b0 && irq_n == 1'b1, "R11 ack/irq", {host_ack, irq_n}, 2'b01);
    chk(card_ce_n == 2'b11 && card_oe_n && card_we_n, "R11 card strobes", {card_ce_n, card_oe_n, card_we_n}, 4'hF);
    chk(card_rst == 2'b00 && ts_route == 2'b00 && ts_out_en == 2'b00, "R11 enables", {card_rst, ts_route, ts_out_en}, 0);
    chk(tuner_rst_n == 2'b11, "R11 tuner resets", tuner_rst_n, 2'b11);
    acc(1'b0, A_CTL2, 0, 8'h0C, 8'hFF, "R11 ctl2 reset value");
    acc(1'b0, A_ADLO, 0, 8'h00, 8'hFF, "R11 addr low reset");
    acc(1'b0, A_INT,  0, 8'h00, 8'hFF, "R11 int reset");

    // R1 address packing
    wr(A_ADLO, 8'hFF);
    acc(1'b0, A_ADLO, 0, 8'hFE, 8'hFF, "R1 addr low bit0 reads 0");
    wr(A_ADHI, 8'hFF);
    acc(1'b0, A_ADHI, 0, 8'h7F, 8'hFF, "R1 addr high bit7 reads 0");
    wr(A_ADLO, 8'h56);
    wr(A_ADHI, 8'h15);
    ea = {7'h15, 7'h2B};
    chk(card_addr == ea, "R1 card address", card_addr, ea);

    // R2 R3 R5 read, slot 0, control space
    wr(A_BUS, 8'h40);
    n0 = acc_cnt;
    acc(1'b0, A_DATA, 0, card_byte(1'b0, 1'b1, ea), 8'hFF, "R3 read byte slot0 ctl");
    chk(acc_cnt == n0 + 1, "R3 one card cycle", acc_cnt - n0, 1);
    chk(seen_ce == 2'b10 && seen_space == 1'b1, "R2 slot0 control space", {seen_ce, seen_space}, 3'b101);
    chk(seen_rd && !seen_wr && seen_addr == ea, "R3 read strobe and address", {seen_rd, seen_wr}, 2'b10);
    chk(last_len == STB_CYC, "R5 strobe length", last_len, STB_CYC);

    // R2 R4 write, slot 1, attribute space
    wr(A_BUS, 8'h80);
    n0 = acc_cnt;
    acc(1'b1, A_DATA, 8'h9C, 0, 0, "");
    chk(acc_cnt == n0 + 1, "R4 one card cycle", acc_cnt - n0, 1);
    chk(seen_wr && !seen_rd && seen_wd == 8'h9C, "R4 write byte", seen_wd, 8'h9C);
    chk(seen_ce == 2'b01 && seen_space == 1'b0, "R2 slot1 attribute space", {seen_ce, seen_space}, 3'b010);

    // R3 read on slot 1
    wr(A_ADLO, 8'h0A);
    ea = {7'h15, 7'h05};
    acc(1'b0, A_DATA, 0, card_byte(1'b1, 1'b0, ea), 8'hFF, "R3 read byte slot1 attr");

    // R5 wait stretch on slot 1
    card_wait_n[1] = 1'b0;
    fork
      acc(1'b0, A_DATA, 0, card_byte(1'b1, 1'b0, ea), 8'hFF, "R3 read byte after wait");
      begin
        wait (!card_oe_n);
        repeat (6) @(negedge clk);
        card_wait_n[1] = 1'b1;
      end
    join
    chk(last_len == 6, "R5 stretched strobe length", last_len, 6);

    // R5 wait on the other slot does not stretch
    card_wait_n[0] = 1'b0;
    acc(1'b0, A_DATA, 0, card_byte(1'b1, 1'b0, ea), 8'hFF, "R5 unselected wait read");
    chk(last_len == STB_CYC, "R5 unselected wait ignored", last_len, STB_CYC);
    card_wait_n[0] = 1'b1;

    // R7 stream routing
    wr(A_BUS, 8'h08);
    chk(ts_route == 2'b01, "R7 route slot0", ts_route, 2'b01);
    wr(A_BUS, 8'h04);
    chk(ts_route == 2'b10, "R7 route slot1", ts_route, 2'b10);

    // R8 card detect and ignored writes
    wr(A_BUS, 8'h03);
    acc(1'b0, A_BUS, 0, 8'h01, 8'h03, "R8 detect bits after write");
    chk(card_rst == 2'b00, "R8 write starts no reset", card_rst, 0);

    // R9 control-2
    wr(A_CTL2, 8'h30);
    chk(ts_out_en == 2'b11 && tuner_rst_n == 2'b00, "R9 ctl2 0x30", {ts_out_en, tuner_rst_n}, 4'b1100);
    wr(A_CTL2, 8'h28);
    chk(ts_out_en == 2'b10 && tuner_rst_n == 2'b01, "R9 ctl2 0x28", {ts_out_en, tuner_rst_n}, 4'b1001);
    acc(1'b0, A_CTL2, 0, 8'h28, 8'hFF, "R9 ctl2 readback");

    // R6 slot 0 reset sequence
    rh0 = 0; rh1 = 0;
    wr(A_BUS, 8'h20);
    wait (card_rst[0]);
    wait (!card_rst[0]);
    @(negedge clk);
    acc(1'b0, A_BUS, 0, 8'h20, 8'h20, "R6 bit held during settle");
    for (int k = 0; k < 40; k++) begin
      acc(1'b0, A_BUS, 0, 0, 0, "");
      if (!last_rd[5]) break;
    end
    chk(!last_rd[5], "R6 slot0 bit self-clears", last_rd[5], 0);
    chk(rh0 == RST_CYC, "R6 slot0 hold length", rh0, RST_CYC);
    chk(rh1 == 0, "R6 slot1 untouched", rh1, 0);

    // R6 slot 1 reset, zero write ignored
    wr(A_BUS, 8'h10);
    wr(A_BUS, 8'h00);
    acc(1'b0, A_BUS, 0, 8'h10, 8'h10, "R6 zero write ignored");
    for (int k = 0; k < 40; k++) begin
      acc(1'b0, A_BUS, 0, 0, 0, "");
      if (!last_rd[4]) break;
    end
    chk(!last_rd[4], "R6 slot1 bit self-clears", last_rd[4], 0);
    chk(rh1 == RST_CYC && rh0 == RST_CYC, "R6 slot1 hold length", rh1, RST_CYC);

    // R10 interrupt
    wr(A_INT, 8'h01);
    acc(1'b0, A_INT, 0, 8'h01, 8'hFF, "R10 enabled, nothing pending");
    card_cd_n[1] = 1'b0;
    repeat (5) @(negedge clk);
    chk(irq_n == 1'b0, "R10 irq on detect change", irq_n, 0);
    acc(1'b0, A_INT, 0, 8'h03, 8'hFF, "R10 pending read");
    acc(1'b0, A_INT, 0, 8'h01, 8'hFF, "R10 pending cleared by read");
    chk(irq_n == 1'b1, "R10 irq released", irq_n, 1);
    acc(1'b0, A_BUS, 0, 8'h00, 8'h03, "R8 slot1 card present");
    wr(A_INT, 8'h00);
    card_cd_n[1] = 1'b1;
    repeat (5) @(negedge clk);
    chk(irq_n == 1'b1, "R10 no irq while disabled", irq_n, 1);
    acc(1'b0, A_INT, 0, 8'h00, 8'hFF, "R10 nothing pending while disabled");

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule